// File: doc/BRIEF.md
# Access-Sequenced Arithmetic Unit

This block is a small math coprocessor that sits on a byte-wide register bus. It offers unsigned division (32 by 16 and 16 by 16 bits), a 16 by 16 multiply, 32-bit logical shifts in either direction and a 32-bit normalize. Software never writes an opcode. The unit infers the operation from the order and number of byte writes to two data ports, A and B, and to a count register. Once the last loading byte arrives, a fixed-latency iterative datapath runs. The results can then be read back a byte at a time through the same two data ports.

Any access to A, B or the count register that does not fit a known sequence sends the sequencer into a fault state. The unit stays there until software writes the status register with its engage bit at zero. Accesses to addresses the unit does not own, and reads of the count and status registers, never disturb a sequence.

The sequencer states are IDLE, LOAD_A (A bytes arriving first), LOAD_AB (divisor bytes after A), LOAD_B (B bytes arriving first), LOAD_BA (multiplicand bytes after B), RUN, READ and FAULT. These are the transitions:
- IDLE→LOAD_A on an A write.
- IDLE→LOAD_B on a B write.
- LOAD_A→LOAD_AB on a B write after 2 or 4 A bytes.
- LOAD_A→RUN on a count write after 4 A bytes.
- LOAD_AB→RUN on the second B write.
- LOAD_B→LOAD_BA on an A write after 2 B bytes.
- LOAD_BA→RUN on the second A write.
- RUN→READ when the latency expires.
- READ→IDLE after the last expected result read.
- Any state→FAULT on a misplaced access.
- Any state→IDLE on a restart write.

Top module: `seqmath_unit`

## Requirements
- R1: Four A writes followed by two B writes divide the 32-bit A value by the 16-bit B value. Bytes are written most significant first. The 32-bit quotient is read as 4 bytes from A, most significant first, and then the 16-bit remainder is read as 2 bytes from B.
- R2: Two A writes followed by two B writes perform a 16 by 16 division. The quotient is read as 2 bytes from A and then the remainder as 2 bytes from B.
- R3: Two B writes followed by two A writes multiply the two 16-bit values. The 32-bit product is read as 4 bytes from A.
- R4: Four A writes followed by a count write shift the 32-bit value, filling with zeros. Count bits [4:0] give the amount, bit 5 set means right and clear means left, and bit 6 is clear. The result is read as 4 bytes from A.
- R5: With count bit 6 set, the value is shifted left until bit 31 is set. The mantissa is read as 4 bytes from A, and then 1 byte is read from B holding the shift count in bits [4:0]. A zero input gives mantissa 0 and exponent 0.
- R6: The status bit 1 (busy) is high for exactly 36 cycles for the 32-bit divide, shift and normalize, and for 24 cycles for the 16-bit divide and the multiply. It rises in the cycle after the final loading write.
- R7: Reads of A or B while busy return unchanged data and do not advance the read-back sequence.
- R8: After the last expected result read, the status bit 0 (engaged) returns to 0.
- R9: An out-of-order access to A, B or the count register sets the status bit 2 (fault), with bit 0 still set. Later accesses to A, B or the count register are ignored until a restart. Reading A or B in IDLE is out of order.
- R10: Writing the status register with bit 0 clear returns the unit to IDLE and clears status bits 0 to 3.
- R11: A division with divisor zero completes in the normal latency. The quotient is all ones and the remainder equals the dividend's low 16 bits. The sticky status bit 3 is set and stays set until a restart.
- R12: The address map is A=0, B=1, count=2, status=3. Accesses to addresses 4 to 7, and reads of the count and status registers, have no effect on a sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |

## Verification
The divide is tried with a divisor that does not divide the dividend, with a divisor whose top bit is set, and with divisor zero. This separates the quotient and remainder byte order and the restoring-step compare from the zero-divisor override. Shifts are run left, right and at the maximum amount, which distinguishes the direction bit from the amount field. Normalize is tried on a mid-size value, on one, on a value with bit 31 already set, and on zero, so every exponent extreme is covered. The broken sequences, the interleaved foreign accesses and the reads during busy show that only A, B and count accesses in the wrong place change the sequencer.

// File: rtl/seqmath_pkg.sv
package seqmath_pkg;

    typedef enum logic [2:0] {
        OP_DIVL,
        OP_DIVS,
        OP_MUL,
        OP_SHIFT,
        OP_NORM
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD_A,
        S_LOAD_AB,
        S_LOAD_B,
        S_LOAD_BA,
        S_RUN,
        S_READ,
        S_FAULT
    } state_e;

    localparam logic [2:0] ADR_A    = 3'd0;
    localparam logic [2:0] ADR_B    = 3'd1;
    localparam logic [2:0] ADR_CNT  = 3'd2;
    localparam logic [2:0] ADR_STAT = 3'd3;

    localparam int CNT_DIR_BIT  = 5;
    localparam int CNT_NORM_BIT = 6;

endpackage

// File: rtl/seqmath_engine.sv
module seqmath_engine
    import seqmath_pkg::*;
#(
    parameter int QW = 32,
    parameter int DW = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   kick,
    input  op_e                    op,
    input  logic [QW-1:0]          opa,
    input  logic [DW-1:0]          opb,
    input  logic [$clog2(QW)-1:0]  shamt,
    input  logic                   dir_r,
    output logic [QW-1:0]          res_q,
    output logic [DW-1:0]          res_r,
    output logic                   idle
);
    localparam int EW = $clog2(QW);
    localparam int SW = EW + 1;

    logic [QW-1:0] acc, acc_n, aux, aux_n;
    logic [DW:0]   rem, rem_n, rem_sh;
    logic [SW-1:0] left, left_n;
    op_e           op_r, op_rn;
    logic          dir_q, dir_n;

    always_comb begin
        acc_n  = acc;
        aux_n  = aux;
        rem_n  = rem;
        left_n = left;
        op_rn  = op_r;
        dir_n  = dir_q;
        rem_sh = {rem[DW-1:0], acc[QW-1]};
        if (kick) begin
            op_rn = op;
            rem_n = '0;
            aux_n = '0;
            unique case (op)
                OP_DIVL, OP_DIVS: begin
                    if (opb == '0) begin
                        acc_n  = '1;
                        rem_n  = {1'b0, opa[DW-1:0]};
                        left_n = '0;
                    end else begin
                        acc_n  = (op == OP_DIVL) ? opa : {opa[DW-1:0], {(QW-DW){1'b0}}};
                        aux_n  = {{(QW-DW){1'b0}}, opb};
                        left_n = (op == OP_DIVL) ? SW'(QW) : SW'(DW);
                    end
                end
                OP_MUL: begin
                    acc_n  = '0;
                    aux_n  = {{(QW-DW){1'b0}}, opa[DW-1:0]};
                    rem_n  = {1'b0, opb};
                    left_n = SW'(DW);
                end
                OP_SHIFT: begin
                    acc_n  = opa;
                    dir_n  = dir_r;
                    left_n = {1'b0, shamt};
                end
                OP_NORM: begin
                    acc_n  = opa;
                    left_n = SW'(QW - 1);
                end
                default: ;
            endcase
        end else if (left != '0) begin
            left_n = left - 1'b1;
            unique case (op_r)
                OP_DIVL, OP_DIVS: begin
                    if (rem_sh >= aux[DW:0]) begin
                        rem_n = rem_sh - aux[DW:0];
                        acc_n = {acc[QW-2:0], 1'b1};
                    end else begin
                        rem_n = rem_sh;
                        acc_n = {acc[QW-2:0], 1'b0};
                    end
                end
                OP_MUL: begin
                    if (rem[0]) acc_n = acc + aux;
                    aux_n = {aux[QW-2:0], 1'b0};
                    rem_n = {1'b0, rem[DW:1]};
                end
                OP_SHIFT: acc_n = dir_q ? {1'b0, acc[QW-1:1]} : {acc[QW-2:0], 1'b0};
                OP_NORM: begin
                    if (acc[QW-1] || acc == '0) begin
                        left_n = '0;
                    end else begin
                        acc_n = {acc[QW-2:0], 1'b0};
                        rem_n = rem + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc   <= '0;
            aux   <= '0;
            rem   <= '0;
            left  <= '0;
            op_r  <= OP_DIVL;
            dir_q <= 1'b0;
        end else begin
            acc   <= acc_n;
            aux   <= aux_n;
            rem   <= rem_n;
            left  <= left_n;
            op_r  <= op_rn;
            dir_q <= dir_n;
        end
    end

    assign res_q = acc;
    assign res_r = rem[DW-1:0];
    assign idle  = (left == '0);

    // R5
    norm_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_r == OP_NORM && left == '0 && acc != '0) |-> acc[QW-1]);

endmodule

// File: rtl/seqmath_seq.sv
module seqmath_seq
    import seqmath_pkg::*;
#(
    parameter int LAT_DIVL  = 36,
    parameter int LAT_DIVS  = 24,
    parameter int LAT_MUL   = 24,
    parameter int LAT_SHIFT = 36,
    parameter int LAT_NORM  = 36
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] addr,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic       sel_norm,
    input  logic       restart,
    output logic       take_a,
    output logic       take_b,
    output logic       kick,
    output op_e        op,
    output logic       fin,
    output logic       busy,
    output logic       engaged,
    output logic       fault,
    output logic [1:0] a_ptr,
    output logic       b_ptr
);
    localparam int LAT_A   = (LAT_DIVL > LAT_SHIFT) ? LAT_DIVL : LAT_SHIFT;
    localparam int LAT_B   = (LAT_DIVS > LAT_MUL) ? LAT_DIVS : LAT_MUL;
    localparam int LAT_C   = (LAT_A > LAT_B) ? LAT_A : LAT_B;
    localparam int LAT_MAX = (LAT_C > LAT_NORM) ? LAT_C : LAT_NORM;
    localparam int CW      = $clog2(LAT_MAX + 1);

    state_e        st, st_n;
    op_e           op_q, op_n;
    logic [2:0]    na, na_n, ra, ra_n;
    logic [1:0]    nb, nb_n, rb, rb_n;
    logic [CW-1:0] cnt, cnt_n;
    logic [1:0]    ap, ap_n;
    logic          bp, bp_n;
    logic          go, kick_q;
    logic          wa, wb, wc, rda, rdb, rdany;

    function automatic logic [CW-1:0] lat_of(input op_e o);
        unique case (o)
            OP_DIVL:  return CW'(LAT_DIVL - 1);
            OP_DIVS:  return CW'(LAT_DIVS - 1);
            OP_MUL:   return CW'(LAT_MUL - 1);
            OP_SHIFT: return CW'(LAT_SHIFT - 1);
            default:  return CW'(LAT_NORM - 1);
        endcase
    endfunction

    assign wa    = wr_en && addr == ADR_A;
    assign wb    = wr_en && addr == ADR_B;
    assign wc    = wr_en && addr == ADR_CNT;
    assign rda   = rd_en && addr == ADR_A;
    assign rdb   = rd_en && addr == ADR_B;
    assign rdany = rda || rdb;

    // transitions
    always_comb begin
        st_n = st; op_n = op_q; na_n = na; nb_n = nb;
        ra_n = ra; rb_n = rb; cnt_n = cnt; ap_n = ap; bp_n = bp;
        go = 1'b0; take_a = 1'b0; take_b = 1'b0;
        unique case (st)
            S_IDLE: begin
                if (wa) begin
                    st_n = S_LOAD_A; na_n = 3'd1; take_a = 1'b1;
                end else if (wb) begin
                    st_n = S_LOAD_B; nb_n = 2'd1; take_b = 1'b1;
                end else if (wc || rdany) st_n = S_FAULT;
            end
            S_LOAD_A: begin
                if (wa) begin
                    if (na < 3'd4) begin na_n = na + 1'b1; take_a = 1'b1; end
                    else st_n = S_FAULT;
                end else if (wb) begin
                    if (na == 3'd2 || na == 3'd4) begin
                        st_n = S_LOAD_AB; nb_n = 2'd1; take_b = 1'b1;
                    end else st_n = S_FAULT;
                end else if (wc) begin
                    if (na == 3'd4) begin go = 1'b1; op_n = sel_norm ? OP_NORM : OP_SHIFT; end
                    else st_n = S_FAULT;
                end else if (rdany) st_n = S_FAULT;
            end
            S_LOAD_AB: begin
                if (wb) begin
                    go = 1'b1; take_b = 1'b1;
                    op_n = (na == 3'd4) ? OP_DIVL : OP_DIVS;
                end else if (wa || wc || rdany) st_n = S_FAULT;
            end
            S_LOAD_B: begin
                if (wb) begin
                    if (nb == 2'd1) begin nb_n = 2'd2; take_b = 1'b1; end
                    else st_n = S_FAULT;
                end else if (wa) begin
                    if (nb == 2'd2) begin st_n = S_LOAD_BA; take_a = 1'b1; end
                    else st_n = S_FAULT;
                end else if (wc || rdany) st_n = S_FAULT;
            end
            S_LOAD_BA: begin
                if (wa) begin go = 1'b1; take_a = 1'b1; op_n = OP_MUL; end
                else if (wb || wc || rdany) st_n = S_FAULT;
            end
            S_RUN: begin
                if (wa || wb || wc) st_n = S_FAULT;
                else if (cnt == '0) begin
                    st_n = S_READ;
                    unique case (op_q)
                        OP_DIVL: begin ra_n = 3'd4; rb_n = 2'd2; ap_n = 2'd3; bp_n = 1'b1; end
                        OP_DIVS: begin ra_n = 3'd2; rb_n = 2'd2; ap_n = 2'd1; bp_n = 1'b1; end
                        OP_NORM: begin ra_n = 3'd4; rb_n = 2'd1; ap_n = 2'd3; bp_n = 1'b0; end
                        default: begin ra_n = 3'd4; rb_n = 2'd0; ap_n = 2'd3; end
                    endcase
                end else cnt_n = cnt - 1'b1;
            end
            S_READ: begin
                if (wa || wb || wc) st_n = S_FAULT;
                else if (rda) begin
                    if (ra != '0) begin
                        ra_n = ra - 1'b1; ap_n = ap - 1'b1;
                        if (ra == 3'd1 && rb == '0) st_n = S_IDLE;
                    end else st_n = S_FAULT;
                end else if (rdb) begin
                    if (ra == '0 && rb != '0) begin
                        rb_n = rb - 1'b1; bp_n = bp - 1'b1;
                        if (rb == 2'd1) st_n = S_IDLE;
                    end else st_n = S_FAULT;
                end
            end
            S_FAULT: ;
            default: st_n = S_FAULT;
        endcase
        if (go) begin
            st_n  = S_RUN;
            cnt_n = lat_of(op_n);
        end
        if (restart) begin
            st_n = S_IDLE; go = 1'b0; take_a = 1'b0; take_b = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= S_IDLE; op_q <= OP_DIVL; na <= '0; nb <= '0;
            ra <= '0; rb <= '0; cnt <= '0; ap <= '0; bp <= '0; kick_q <= 1'b0;
        end else begin
            st <= st_n; op_q <= op_n; na <= na_n; nb <= nb_n;
            ra <= ra_n; rb <= rb_n; cnt <= cnt_n; ap <= ap_n; bp <= bp_n;
            kick_q <= go;
        end
    end

    // outputs
    always_comb begin
        busy    = (st == S_RUN);
        engaged = (st != S_IDLE);
        fault   = (st == S_FAULT);
        fin     = (st == S_RUN) && (st_n == S_READ);
        kick    = kick_q;
        op      = op_q;
        a_ptr   = ap;
        b_ptr   = bp;
    end

    // R6
    busy_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_en));

    // R9
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_FAULT && !restart) |=> st == S_FAULT);

    // R7
    busy_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RUN && !fin) |=> ($stable(a_ptr) && $stable(b_ptr)));

    // R8
    read_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_READ) |-> (ra != '0 || rb != '0));

endmodule

// File: rtl/seqmath_unit.sv
module seqmath_unit
    import seqmath_pkg::*;
#(
    parameter int LAT_DIVL  = 36,
    parameter int LAT_DIVS  = 24,
    parameter int LAT_MUL   = 24,
    parameter int LAT_SHIFT = 36,
    parameter int LAT_NORM  = 36
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] addr,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata
);
    localparam int QW = 32;
    localparam int DW = 16;
    localparam int EW = $clog2(QW);

    logic [QW-1:0] op_a, res_a, eng_q;
    logic [DW-1:0] op_b, res_b, eng_r;
    logic [7:0]    cnt_reg;
    logic          dz, eng_idle;
    logic          take_a, take_b, kick, fin, busy, engaged, fault, b_ptr, restart;
    logic [1:0]    a_ptr;
    op_e           op;

    assign restart = wr_en && addr == ADR_STAT && !wdata[0];

    seqmath_seq #(
        .LAT_DIVL (LAT_DIVL),
        .LAT_DIVS (LAT_DIVS),
        .LAT_MUL  (LAT_MUL),
        .LAT_SHIFT(LAT_SHIFT),
        .LAT_NORM (LAT_NORM)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .sel_norm(wdata[CNT_NORM_BIT]),
        .restart (restart),
        .take_a  (take_a),
        .take_b  (take_b),
        .kick    (kick),
        .op      (op),
        .fin     (fin),
        .busy    (busy),
        .engaged (engaged),
        .fault   (fault),
        .a_ptr   (a_ptr),
        .b_ptr   (b_ptr)
    );

    seqmath_engine #(.QW(QW), .DW(DW)) u_eng (
        .clk  (clk),
        .rst_n(rst_n),
        .kick (kick),
        .op   (op),
        .opa  (op_a),
        .opb  (op_b),
        .shamt(cnt_reg[EW-1:0]),
        .dir_r(cnt_reg[CNT_DIR_BIT]),
        .res_q(eng_q),
        .res_r(eng_r),
        .idle (eng_idle)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_a    <= '0;
            op_b    <= '0;
            cnt_reg <= '0;
            res_a   <= '0;
            res_b   <= '0;
            dz      <= 1'b0;
        end else begin
            if (take_a) op_a <= {op_a[QW-9:0], wdata};
            if (take_b) op_b <= {op_b[DW-9:0], wdata};
            if (wr_en && addr == ADR_CNT) cnt_reg <= wdata;
            if (fin) begin
                res_a <= eng_q;
                res_b <= eng_r;
                if ((op == OP_DIVL || op == OP_DIVS) && op_b == '0) dz <= 1'b1;
            end
            if (restart) dz <= 1'b0;
        end
    end

    always_comb begin
        unique case (addr)
            ADR_A:    rdata = res_a[{a_ptr, 3'b000} +: 8];
            ADR_B:    rdata = res_b[{b_ptr, 3'b000} +: 8];
            ADR_CNT:  rdata = cnt_reg;
            ADR_STAT: rdata = {4'b0000, dz, fault, busy, engaged};
            default:  rdata = 8'h00;
        endcase
    end

    // R1
    fin_engine_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> eng_idle);

    // R11
    dz_quot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dz) |-> res_a[DW-1:0] == '1);

endmodule

// File: tb/tb_seqmath_unit.sv
module tb_seqmath_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    int checks = 0;
    int errors = 0;

    seqmath_unit dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .rd_en(rd_en), .wdata(wdata), .rdata(rdata)
    );

    always #4 clk = ~clk;

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_busy(output int n);
        logic [7:0] s;
        n = 0;
        for (int i = 0; i < 100; i++) begin
            rd(3'd3, s);
            if (s[1]) n++;
            else break;
        end
    endtask

    task automatic get_a(input int nb, output logic [31:0] v);
        logic [7:0] b;
        v = '0;
        for (int i = 0; i < nb; i++) begin rd(3'd0, b); v = {v[23:0], b}; end
    endtask

    task automatic get_b(input int nb, output logic [15:0] v);
        logic [7:0] b;
        v = '0;
        for (int i = 0; i < nb; i++) begin rd(3'd1, b); v = {v[7:0], b}; end
    endtask

    task automatic load_a4(input logic [31:0] v);
        for (int i = 3; i >= 0; i--) wr(3'd0, v[i*8 +: 8]);
    endtask

    task automatic check_idle(input string tag);
        logic [7:0] s;
        rd(3'd3, s);
        chk(s[0] == 1'b0 && s[2] == 1'b0, tag, {24'h0, s}, 32'h0);
    endtask

    task automatic t_reset();
        logic [7:0] s;
        rd(3'd3, s);
        chk(s == 8'h00, "R10 reset status", {24'h0, s}, 32'h0);
    endtask

    task automatic t_divl(input logic [31:0] dvd, input logic [15:0] dvs);
        int n; logic [31:0] q, eq; logic [15:0] r, er;
        load_a4(dvd);
        wr(3'd1, dvs[15:8]); wr(3'd1, dvs[7:0]);
        wait_busy(n);
        chk(n == 36, "R6 div32 latency", n, 36);
        get_a(4, q); get_b(2, r);
        eq = (dvs == 0) ? 32'hFFFF_FFFF : dvd / dvs;
        er = (dvs == 0) ? dvd[15:0] : 16'(dvd % dvs);
        chk(q == eq, (dvs == 0) ? "R11 div-zero quotient" : "R1 div32 quotient", q, eq);
        chk(r == er, (dvs == 0) ? "R11 div-zero remainder" : "R1 div32 remainder", r, er);
        check_idle("R8 idle after div32 reads");
    endtask

    task automatic t_divs(input logic [15:0] dvd, input logic [15:0] dvs);
        int n; logic [31:0] q; logic [15:0] r;
        wr(3'd0, dvd[15:8]); wr(3'd0, dvd[7:0]);
        wr(3'd1, dvs[15:8]); wr(3'd1, dvs[7:0]);
        wait_busy(n);
        chk(n == 24, "R6 div16 latency", n, 24);
        get_a(2, q); get_b(2, r);
        chk(q[15:0] == dvd / dvs, "R2 div16 quotient", q, {16'h0, dvd / dvs});
        chk(r == dvd % dvs, "R2 div16 remainder", r, {16'h0, dvd % dvs});
        check_idle("R8 idle after div16 reads");
    endtask

    task automatic t_mul(input logic [15:0] x, input logic [15:0] y);
        int n; logic [31:0] p, ep; logic [7:0] junk;
        wr(3'd1, y[15:8]);
        wr(3'd5, 8'hA5);
        rd(3'd6, junk);
        wr(3'd1, y[7:0]);
        rd(3'd3, junk);
        rd(3'd2, junk);
        wr(3'd0, x[15:8]); wr(3'd0, x[7:0]);
        wait_busy(n);
        chk(n == 24, "R6 mul latency", n, 24);
        get_a(4, p);
        ep = 32'(x) * 32'(y);
        chk(p == ep, "R3 R12 product with foreign accesses", p, ep);
        check_idle("R8 R12 idle after mul");
    endtask

    task automatic t_shift(input logic [31:0] v, input int amt, input bit right);
        int n; logic [31:0] s, es;
        load_a4(v);
        wr(3'd2, {2'b00, right, 5'(amt)});
        wait_busy(n);
        chk(n == 36, "R6 shift latency", n, 36);
        get_a(4, s);
        es = right ? v >> amt : v << amt;
        chk(s == es, "R4 shift result", s, es);
        check_idle("R8 idle after shift");
    endtask

    task automatic t_norm(input logic [31:0] v);
        int n; logic [31:0] m, em; logic [15:0] e; int ee;
        em = v; ee = 0;
        if (v != 0) while (!em[31]) begin em = em << 1; ee++; end
        load_a4(v);
        wr(3'd2, 8'h40);
        wait_busy(n);
        chk(n == 36, "R6 normalize latency", n, 36);
        get_a(4, m); get_b(1, e);
        chk(m == em, "R5 mantissa", m, em);
        chk(e == 16'(ee), "R5 exponent", e, ee);
        check_idle("R8 idle after normalize");
    endtask

    task automatic t_divzero();
        logic [7:0] s;
        t_divl(32'h89AB_CDEF, 16'h0000);
        rd(3'd3, s);
        chk(s[3] == 1'b1, "R11 zero flag set", {24'h0, s}, 32'h08);
        t_divs(16'd1000, 16'd7);
        rd(3'd3, s);
        chk(s[3] == 1'b1, "R11 zero flag sticky", {24'h0, s}, 32'h08);
        wr(3'd3, 8'h00);
        rd(3'd3, s);
        chk(s == 8'h00, "R10 R11 restart clears flag", {24'h0, s}, 32'h0);
    endtask

    task automatic t_fault();
        logic [7:0] s;
        wr(3'd0, 8'h11); wr(3'd0, 8'h22);
        wr(3'd2, 8'h03);
        rd(3'd3, s);
        chk(s == 8'h05, "R9 count after two A bytes faults", {24'h0, s}, 32'h05);
        load_a4(32'h0000_0001);
        wr(3'd2, 8'h00);
        rd(3'd3, s);
        chk(s == 8'h05, "R9 accesses ignored in fault", {24'h0, s}, 32'h05);
        wr(3'd3, 8'h00);
        rd(3'd3, s);
        chk(s == 8'h00, "R10 restart to idle", {24'h0, s}, 32'h0);
        rd(3'd0, s);
        rd(3'd3, s);
        chk(s == 8'h05, "R9 read of A in idle faults", {24'h0, s}, 32'h05);
        wr(3'd3, 8'h00);
        t_mul(16'h1234, 16'h00FF);
    endtask

    task automatic t_busy_read();
        int n; logic [7:0] b1, b2, s; logic [31:0] q; logic [15:0] r;
        load_a4(32'd100000);
        wr(3'd1, 8'h01); wr(3'd1, 8'h2C);
        rd(3'd0, b1);
        rd(3'd1, s);
        rd(3'd0, b2);
        chk(b1 == b2, "R7 busy reads stable", b2, b1);
        rd(3'd3, s);
        chk(s[2] == 1'b0 && s[1] == 1'b1, "R7 busy reads do not fault", {24'h0, s}, 32'h03);
        wait_busy(n);
        chk(n == 32, "R6 busy remainder of window", n, 32);
        get_a(4, q); get_b(2, r);
        chk(q == 32'd333, "R7 read sequence not advanced", q, 32'd333);
        chk(r == 16'd100, "R7 remainder after busy reads", r, 16'd100);
        check_idle("R8 idle after busy-read case");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_divl(32'h1234_5678, 16'h1234);
        t_divl(32'hFFFF_FFFF, 16'h8001);
        t_divs(16'd50000, 16'd321);
        t_mul(16'hFFFF, 16'hFFFF);
        t_shift(32'h1234_5678, 4, 1'b0);
        t_shift(32'h1234_5678, 8, 1'b1);
        t_shift(32'h8000_0000, 31, 1'b1);
        t_norm(32'h0000_1234);
        t_norm(32'h0000_0001);
        t_norm(32'h8000_0000);
        t_norm(32'h0000_0000);
        t_divzero();
        t_fault();
        t_busy_read();
        summary();
        $finish;
    end
endmodule